// File: doc/BRIEF.md
# Day-Counting Real-Time Clock with Alarm

This block is a calendar-free real-time clock that sits behind a 16-bit register port. A one-cycle reference tick enable is divided down to one second by a fractional prescaler. The divisor comes from a two-bit selector in the control register, and it can be the 32768, 32000 or 38400 ticks-per-second rate. Time is held as separate seconds, minutes, hours and day fields. Hours and minutes share one register word.

On every one-second update, the advanced time is compared with a programmable alarm. The same prescaler also produces a 2 Hz tick and eight periodic rates from 4 Hz to 512 Hz. Each event latches a bit in a status register, and software clears a bit by writing one to it. An enable register masks which latched events drive the interrupt line. Software programs the time, the alarm and the control word through the register port. It then services the interrupt by reading the status register and writing back the bits it has handled.

Top module: `rtc_day_alarm`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The control word at byte offset 0x10 reads back as written in bits 7:5 and reads 0 elsewhere. Bit 7 runs the clock. Bits 6:5 select the number of reference ticks that make one second: 00 selects FREQ0, 01 selects FREQ1, 10 selects FREQ2, and 11 behaves as 00. With `ref_tick` high every cycle, the seconds field advances exactly that many clock edges after the last time-register write.
- R3: A write to a time register loads the field at once. The register map by byte offset is: hour in bits 12:8 and minute in bits 5:0 at 0x00, seconds in bits 5:0 at 0x04, day at 0x20. The write also restarts the sub-second prescaler, so the next advance comes one full second after the write. Accesses whose `bus_addr[1:0]` are nonzero are ignored.
- R4: Seconds and minutes each count 0 to 59 and then carry into the next field.
- R5: Hours count 0 to 23 and carry into the day counter. The day counter is DAY_W bits wide and wraps from all-ones to 0.
- R6: While control bit 7 is 0, the prescaler and all time fields hold their values and no tick events occur.
- R7: The alarm registers share the time layout: hour/minute at 0x08, seconds at 0x0C, day at 0x24. Status bit 2 sets on the one-second update whose new time equals the alarm in all four fields. It latches even when enable bit 2 is 0.
- R8: Status bit 4 sets on each 1 Hz tick and status bit 7 sets on each 2 Hz tick.
- R9: Status bits 15:8 set on periodic ticks at 4, 8, 16, 32, 64, 128, 256 and 512 Hz, bit 8 being 4 Hz. With FREQ0 selected and FREQ0 = 2048, bit 8+k first sets 2^(9-k) edges after a time write.
- R10: The status register is at 0x14. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A bit that clears and sets in the same cycle ends up set.
- R11: `irq` is high exactly while the bitwise AND of status and the enable register (0x18) is nonzero.
- R12: Only status and enable bits 2, 4, 7 and 15:8 exist. All other bits of both registers read 0, so the enable register reads 0xFF94 after 0xFFFF is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_tick | input | 1 | One-cycle enable marking a reference-clock period |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 6 | Byte offset of the accessed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
A register write lands on the clock edge that samples it, and the read port shows the new value in the following cycle because the read path is combinational. Tick events come from combinational pulses. The seconds field, the status bits and `irq` therefore all change on the same edge: the edge that carries the last reference tick of the period, which is edge E0+F after a time write at edge E0. The bench holds `ref_tick` high, counts edges from each write, and samples once on the edge before an expected change and once on the edge of the change, always one time unit after the edge. This pins the exact cycle of every second rollover, alarm hit and periodic rate tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Sub-second resolution: 2**SUB_W prescaler steps per second.
  localparam int unsigned SUB_W     = 10;
  localparam int unsigned NUM_RATES = 8;

  // Word index (byte offset >> 2) of each register.
  localparam logic [3:0] IDX_HM      = 4'h0;
  localparam logic [3:0] IDX_SEC     = 4'h1;
  localparam logic [3:0] IDX_ALM_HM  = 4'h2;
  localparam logic [3:0] IDX_ALM_SEC = 4'h3;
  localparam logic [3:0] IDX_CTRL    = 4'h4;
  localparam logic [3:0] IDX_STAT    = 4'h5;
  localparam logic [3:0] IDX_IEN     = 4'h6;
  localparam logic [3:0] IDX_DAY     = 4'h8;
  localparam logic [3:0] IDX_ALM_DAY = 4'h9;

  // Event bit positions in status / enable.
  localparam int unsigned EV_ALARM = 2;
  localparam int unsigned EV_SEC   = 4;
  localparam int unsigned EV_HALF  = 7;
  localparam int unsigned EV_RATE0 = 8;
  localparam logic [15:0] EV_MASK  = 16'hFF94;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } hms_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int unsigned FREQ0 = 32768,
  parameter int unsigned FREQ1 = 32000,
  parameter int unsigned FREQ2 = 38400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 ref_tick,
  input  logic                 restart,
  input  logic [1:0]           sel,
  output logic                 tick_sec,
  output logic                 tick_half,
  output logic [NUM_RATES-1:0] tick_rate
);
  localparam int unsigned STEP_ADD = 1 << SUB_W;
  localparam int unsigned MAX_F01  = (FREQ0 > FREQ1) ? FREQ0 : FREQ1;
  localparam int unsigned MAX_F    = (MAX_F01 > FREQ2) ? MAX_F01 : FREQ2;
  localparam int unsigned ACC_W    = $clog2(MAX_F + STEP_ADD + 1);

  logic [ACC_W-1:0] acc_q, acc_d, acc_sum, div_sel;
  logic [SUB_W-1:0] frac_q, frac_d, frac_inc;
  logic             step, pre_en;

  always_comb begin
    case (sel)
      2'd1:    div_sel = ACC_W'(FREQ1);
      2'd2:    div_sel = ACC_W'(FREQ2);
      default: div_sel = ACC_W'(FREQ0);
    endcase
  end

  // Fractional divider: add 2**SUB_W per reference tick, subtract the
  // selected frequency on each sub-second step.
  assign acc_sum  = acc_q + ACC_W'(STEP_ADD);
  assign step     = run && ref_tick && !restart && (acc_sum >= div_sel);
  assign frac_inc = frac_q + SUB_W'(1);
  assign pre_en   = restart || (run && ref_tick);

  always_comb begin
    acc_d  = acc_q;
    frac_d = frac_q;
    if (restart) begin
      acc_d  = '0;
      frac_d = '0;
    end else if (step) begin
      acc_d  = acc_sum - div_sel;
      frac_d = frac_inc;
    end else begin
      acc_d  = acc_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      frac_q <= '0;
    end else if (pre_en) begin
      acc_q  <= acc_d;
      frac_q <= frac_d;
    end
  end

  assign tick_sec  = step && (frac_inc == '0);
  assign tick_half = step && (frac_inc[SUB_W-2:0] == '0);

  // Rate k runs at 2**(k+2) Hz: 2**(SUB_W-2-k) steps per period.
  generate
    for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
      localparam int unsigned LOWB = SUB_W - 2 - k;
      assign tick_rate[k] = step && (frac_inc[LOWB-1:0] == '0);
    end
  endgenerate

  p_restart_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick_sec);
  p_half_on_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sec |-> tick_half);
  p_rates_on_sec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sec |-> ($countones(tick_rate) == NUM_RATES));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int unsigned DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_sec,
  input  logic             ld_hm,
  input  logic             ld_sec,
  input  logic             ld_day,
  input  logic             ld_alm_hm,
  input  logic             ld_alm_sec,
  input  logic             ld_alm_day,
  input  logic [4:0]       wr_hour,
  input  logic [5:0]       wr_min,
  input  logic [5:0]       wr_sec,
  input  logic [DAY_W-1:0] wr_day,
  output hms_t             now_hms,
  output logic [DAY_W-1:0] now_day,
  output hms_t             alm_hms,
  output logic [DAY_W-1:0] alm_day,
  output logic             alarm_hit
);
  hms_t             now_q, now_d, adv_hms, alm_q, alm_d;
  logic [DAY_W-1:0] day_q, day_d, adv_day, aday_q, aday_d;
  logic             time_en, alm_en;

  // Advanced time: the value after one second.
  always_comb begin
    adv_hms = now_q;
    adv_day = day_q;
    if (now_q.sec >= 6'd59) begin
      adv_hms.sec = '0;
      if (now_q.min >= 6'd59) begin
        adv_hms.min = '0;
        if (now_q.hour >= 5'd23) begin
          adv_hms.hour = '0;
          adv_day      = day_q + DAY_W'(1);
        end else begin
          adv_hms.hour = now_q.hour + 5'd1;
        end
      end else begin
        adv_hms.min = now_q.min + 6'd1;
      end
    end else begin
      adv_hms.sec = now_q.sec + 6'd1;
    end
  end

  always_comb begin
    now_d = tick_sec ? adv_hms : now_q;
    day_d = tick_sec ? adv_day : day_q;
    if (ld_hm) begin
      now_d.hour = wr_hour;
      now_d.min  = wr_min;
    end
    if (ld_sec) now_d.sec = wr_sec;
    if (ld_day) day_d = wr_day;

    alm_d  = alm_q;
    aday_d = aday_q;
    if (ld_alm_hm) begin
      alm_d.hour = wr_hour;
      alm_d.min  = wr_min;
    end
    if (ld_alm_sec) alm_d.sec = wr_sec;
    if (ld_alm_day) aday_d = wr_day;
  end

  assign time_en = tick_sec || ld_hm || ld_sec || ld_day;
  assign alm_en  = ld_alm_hm || ld_alm_sec || ld_alm_day;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      day_q <= '0;
    end else if (time_en) begin
      now_q <= now_d;
      day_q <= day_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q  <= '0;
      aday_q <= '0;
    end else if (alm_en) begin
      alm_q  <= alm_d;
      aday_q <= aday_d;
    end
  end

  assign alarm_hit = tick_sec && (adv_hms == alm_q) && (adv_day == aday_q);
  assign now_hms   = now_q;
  assign now_day   = day_q;
  assign alm_hms   = alm_q;
  assign alm_day   = aday_q;

  p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sec && !ld_sec && now_q.sec < 6'd59) |=> (now_q.sec == $past(now_q.sec) + 6'd1));
  p_min_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sec && !ld_hm && !ld_sec && now_q.sec == 6'd59 && now_q.min < 6'd59)
      |=> (now_q.sec == 6'd0 && now_q.min == $past(now_q.min) + 6'd1));
  p_day_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sec && !ld_hm && !ld_sec && !ld_day && day_q == '1 && now_q.hour == 5'd23 &&
     now_q.min == 6'd59 && now_q.sec == 6'd59) |=> (day_q == '0 && now_q == '0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_sec && !ld_hm && !ld_sec && !ld_day) |=> ($stable(now_q) && $stable(day_q)));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] evt,
  input  logic        stat_we,
  input  logic        ien_we,
  input  logic [15:0] wdata,
  output logic [15:0] status,
  output logic [15:0] enable,
  output logic        irq
);
  logic [15:0] stat_q, stat_d, ien_q, clr_mask, set_mask;
  logic        stat_en;

  assign set_mask = evt & EV_MASK;
  assign clr_mask = stat_we ? wdata : 16'h0000;
  assign stat_en  = stat_we || (set_mask != 16'h0000);
  // Set wins over a clear arriving in the same cycle.
  assign stat_d   = (stat_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (ien_we) begin
      ien_q <= wdata & EV_MASK;
    end
  end

  assign status = stat_q;
  assign enable = ien_q;
  assign irq    = |(stat_q & ien_q);

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> ((stat_q & $past(wdata & ~set_mask)) == 16'h0000));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_alarm_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt[EV_ALARM] |=> stat_q[EV_ALARM]);
endmodule

// File: rtl/rtc_day_alarm.sv
module rtc_day_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned DAY_W = 16,
  parameter int unsigned FREQ0 = 32768,
  parameter int unsigned FREQ1 = 32000,
  parameter int unsigned FREQ2 = 38400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  logic [3:0]           widx;
  logic                 wr_ok;
  logic                 ld_hm, ld_sec, ld_day, ld_alm_hm, ld_alm_sec, ld_alm_day;
  logic                 ctrl_we, stat_we, ien_we, restart;
  logic                 run_q, run_d;
  logic [1:0]           sel_q, sel_d;
  logic                 tick_sec, tick_half, alarm_hit;
  logic [NUM_RATES-1:0] tick_rate;
  logic [15:0]          evt, status, enable, rd;
  hms_t                 now_hms, alm_hms;
  logic [DAY_W-1:0]     now_day, alm_day;

  assign widx  = bus_addr[5:2];
  assign wr_ok = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);

  assign ld_hm      = wr_ok && (widx == IDX_HM);
  assign ld_sec     = wr_ok && (widx == IDX_SEC);
  assign ld_day     = wr_ok && (widx == IDX_DAY);
  assign ld_alm_hm  = wr_ok && (widx == IDX_ALM_HM);
  assign ld_alm_sec = wr_ok && (widx == IDX_ALM_SEC);
  assign ld_alm_day = wr_ok && (widx == IDX_ALM_DAY);
  assign ctrl_we    = wr_ok && (widx == IDX_CTRL);
  assign stat_we    = wr_ok && (widx == IDX_STAT);
  assign ien_we     = wr_ok && (widx == IDX_IEN);
  assign restart    = ld_hm || ld_sec || ld_day;

  // Control register: run enable and reference select.
  assign run_d = bus_wdata[7];
  assign sel_d = bus_wdata[6:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= 2'b00;
    end else if (ctrl_we) begin
      run_q <= run_d;
      sel_q <= sel_d;
    end
  end

  rtc_prescaler #(
    .FREQ0(FREQ0),
    .FREQ1(FREQ1),
    .FREQ2(FREQ2)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .ref_tick (ref_tick),
    .restart  (restart),
    .sel      (sel_q),
    .tick_sec (tick_sec),
    .tick_half(tick_half),
    .tick_rate(tick_rate)
  );

  rtc_timekeeper #(
    .DAY_W(DAY_W)
  ) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_sec  (tick_sec),
    .ld_hm     (ld_hm),
    .ld_sec    (ld_sec),
    .ld_day    (ld_day),
    .ld_alm_hm (ld_alm_hm),
    .ld_alm_sec(ld_alm_sec),
    .ld_alm_day(ld_alm_day),
    .wr_hour   (bus_wdata[12:8]),
    .wr_min    (bus_wdata[5:0]),
    .wr_sec    (bus_wdata[5:0]),
    .wr_day    (bus_wdata[DAY_W-1:0]),
    .now_hms   (now_hms),
    .now_day   (now_day),
    .alm_hms   (alm_hms),
    .alm_day   (alm_day),
    .alarm_hit (alarm_hit)
  );

  always_comb begin
    evt                              = '0;
    evt[EV_ALARM]                    = alarm_hit;
    evt[EV_SEC]                      = tick_sec;
    evt[EV_HALF]                     = tick_half;
    evt[EV_RATE0 +: NUM_RATES]       = tick_rate;
  end

  rtc_irq_ctrl u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .stat_we(stat_we),
    .ien_we (ien_we),
    .wdata  (bus_wdata),
    .status (status),
    .enable (enable),
    .irq    (irq)
  );

  always_comb begin
    rd = '0;
    case (widx)
      IDX_HM:      rd = {3'b000, now_hms.hour, 2'b00, now_hms.min};
      IDX_SEC:     rd = {10'h000, now_hms.sec};
      IDX_ALM_HM:  rd = {3'b000, alm_hms.hour, 2'b00, alm_hms.min};
      IDX_ALM_SEC: rd = {10'h000, alm_hms.sec};
      IDX_CTRL:    rd = {8'h00, run_q, sel_q, 5'h00};
      IDX_STAT:    rd = status;
      IDX_IEN:     rd = enable;
      IDX_DAY:     rd = 16'(now_day);
      IDX_ALM_DAY: rd = 16'(alm_day);
      default:     rd = '0;
    endcase
  end

  assign bus_rdata = rd;

  p_stopped_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !restart) |=> $stable(status));
endmodule

// File: tb/rtc_day_alarm_tb_top.sv
module rtc_day_alarm_tb_top;
  localparam int unsigned F0 = 2048;
  localparam int unsigned F1 = 2000;
  localparam int unsigned F2 = 2400;

  logic        clk, rst_n, ref_tick, bus_sel, bus_we, irq;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  int n_chk = 0;
  int n_fail = 0;

  rtc_day_alarm #(.DAY_W(9), .FREQ0(F0), .FREQ1(F1), .FREQ2(F2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // 50 MHz: 20 ns period.
  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] day;
    logic [7:0]  hr, mn, sc;
    logic [15:0] eday;
    logic [7:0]  ehr, emn, esc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd0,   8'd0,  8'd0,  8'd5,  16'd0,   8'd0,  8'd0,  8'd6},
    '{2'd1, 16'd0,   8'd0,  8'd0,  8'd59, 16'd0,   8'd0,  8'd1,  8'd0},
    '{2'd2, 16'd0,   8'd0,  8'd59, 8'd59, 16'd0,   8'd1,  8'd0,  8'd0},
    '{2'd0, 16'd3,   8'd23, 8'd59, 8'd59, 16'd4,   8'd0,  8'd0,  8'd0},
    '{2'd3, 16'd511, 8'd23, 8'd59, 8'd59, 16'd0,   8'd0,  8'd0,  8'd0},
    '{2'd1, 16'd100, 8'd12, 8'd34, 8'd56, 16'd100, 8'd12, 8'd34, 8'd57}
  };

  function automatic int unsigned freq_of(input logic [1:0] s);
    case (s)
      2'd1:    return F1;
      2'd2:    return F2;
      default: return F0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rv;
    rst_n = 1'b0; ref_tick = 1'b1; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_edges(1);

    // R1: reset state of every register and the interrupt line.
    foreach (VECS[i]) begin end
    begin
      logic [5:0] addrs [9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24};
      for (int i = 0; i < 9; i++) begin
        bus_read(addrs[i], rv);
        check("R1", "register after reset", rv, 16'h0000);
      end
    end
    check("R1", "irq after reset", irq, 1'b0);

    // R3 immediate load, R6 hold while stopped.
    bus_write(6'h00, 16'h0A1B);
    bus_read(6'h00, rv);
    check("R3", "hour/minute load", rv, 16'h0A1B);
    bus_write(6'h04, 16'd33);
    wait_edges(3000);
    bus_read(6'h04, rv);
    check("R6", "seconds held while stopped", rv, 16'd33);
    bus_read(6'h00, rv);
    check("R6", "hour/minute held while stopped", rv, 16'h0A1B);
    bus_read(6'h14, rv);
    check("R6", "no events while stopped", rv, 16'h0000);

    // R2: control read-back, reserved bits dropped.
    bus_write(6'h10, 16'hFFFF);
    bus_read(6'h10, rv);
    check("R2", "control read-back", rv, 16'h00E0);

    // Unaligned write ignored (R3).
    bus_write(6'h05, 16'd40);
    bus_read(6'h04, rv);
    check("R3", "unaligned write ignored", rv, 16'd33);

    // Vector table: carries, wraps and period per reference select (R2 R4 R5).
    for (int v = 0; v < NV; v++) begin
      int unsigned f;
      f = freq_of(VECS[v].sel);
      bus_write(6'h10, {8'h00, 1'b1, VECS[v].sel, 5'h00});
      bus_write(6'h20, VECS[v].day);
      bus_write(6'h00, {VECS[v].hr, VECS[v].mn});
      bus_write(6'h04, {8'h00, VECS[v].sc});
      wait_edges(int'(f) - 1);
      bus_read(6'h04, rv);
      check("R2", "seconds one edge before period end", rv, {8'h00, VECS[v].sc});
      wait_edges(1);
      bus_read(6'h04, rv);
      check("R4", "seconds after one second", rv, {8'h00, VECS[v].esc});
      bus_read(6'h00, rv);
      check("R4", "hour/minute after one second", rv, {VECS[v].ehr, VECS[v].emn});
      bus_read(6'h20, rv);
      check("R5", "day after one second", rv, VECS[v].eday);
    end

    // R3: a second write restarts the prescaler.
    bus_write(6'h10, 16'h0080);
    bus_write(6'h04, 16'd10);
    wait_edges(1500);
    bus_write(6'h04, 16'd20);
    wait_edges(int'(F0) - 1);
    bus_read(6'h04, rv);
    check("R3", "no advance before full period after reload", rv, 16'd20);
    wait_edges(1);
    bus_read(6'h04, rv);
    check("R3", "advance one full period after reload", rv, 16'd21);

    // R7 R8 R10 R11 R12: alarm with interrupt enabled.
    bus_write(6'h18, 16'h0004);
    bus_write(6'h24, 16'd2);
    bus_write(6'h08, 16'h0506);
    bus_write(6'h0C, 16'd7);
    bus_write(6'h20, 16'd2);
    bus_write(6'h00, 16'h0506);
    bus_write(6'h04, 16'd6);
    bus_write(6'h14, 16'hFFFF);
    wait_edges(int'(F0) - 2);
    bus_read(6'h14, rv);
    check("R7", "alarm not yet pending", rv & 16'h0004, 16'h0000);
    check("R11", "irq low before alarm", irq, 1'b0);
    wait_edges(1);
    bus_read(6'h14, rv);
    check("R7", "alarm pending at match", rv & 16'h0004, 16'h0004);
    check("R8", "1 Hz status set", rv & 16'h0010, 16'h0010);
    check("R11", "irq high on enabled alarm", irq, 1'b1);
    bus_write(6'h14, 16'h0004);
    bus_read(6'h14, rv);
    check("R10", "alarm bit cleared by one", rv & 16'h0004, 16'h0000);
    check("R10", "1 Hz bit kept by zero", rv & 16'h0010, 16'h0010);
    check("R12", "reserved status bits zero", rv & 16'h006B, 16'h0000);
    check("R11", "irq low after clear", irq, 1'b0);

    // R7: alarm latched with interrupt masked.
    bus_write(6'h18, 16'h0000);
    bus_write(6'h04, 16'd6);
    bus_write(6'h14, 16'hFFFF);
    wait_edges(int'(F0) - 1);
    bus_read(6'h14, rv);
    check("R7", "alarm pending while masked", rv & 16'h0004, 16'h0004);
    check("R11", "irq low while masked", irq, 1'b0);

    // R12: enable register holds only defined bits.
    bus_write(6'h18, 16'hFFFF);
    bus_read(6'h18, rv);
    check("R12", "enable register mask", rv, 16'hFF94);

    // R9 R8 R11: periodic rate phases.
    bus_write(6'h18, 16'h8000);
    bus_write(6'h04, 16'd0);
    bus_write(6'h14, 16'hFFFF);
    wait_edges(2);
    bus_read(6'h14, rv);
    check("R9", "no rate tick before edge 4", rv, 16'h0000);
    check("R11", "irq low before 512 Hz tick", irq, 1'b0);
    wait_edges(1);
    bus_read(6'h14, rv);
    check("R9", "512 Hz at edge 4", rv, 16'h8000);
    check("R11", "irq high on 512 Hz", irq, 1'b1);
    wait_edges(4);
    bus_read(6'h14, rv);
    check("R9", "256 Hz at edge 8", rv, 16'hC000);
    wait_edges(503);
    bus_read(6'h14, rv);
    check("R9", "all but 4 Hz at edge 511", rv, 16'hFE00);
    wait_edges(1);
    bus_read(6'h14, rv);
    check("R9", "4 Hz at edge 512", rv, 16'hFF00);
    wait_edges(511);
    bus_read(6'h14, rv);
    check("R8", "no 2 Hz at edge 1023", rv, 16'hFF00);
    wait_edges(1);
    bus_read(6'h14, rv);
    check("R8", "2 Hz at edge 1024", rv, 16'hFF80);

    summary();
    $finish;
  end
endmodule